// File: doc/BRIEF.md
# Command-Phase Parallel Register Interface

This block is the byte-wide microcontroller front end of a USB device controller. A host processor reaches it through chip select, a read strobe, a write strobe and one address bit. With the address bit high, a write delivers a command opcode. With it low, each access is one data byte that belongs to the last opcode. Each opcode carries a fixed budget of data bytes, and that budget is shared by reads and writes. Data accesses beyond the budget have no effect.

Behind the bus sit the device address and function-enable register, the endpoint-enable bit, a two-byte mode register (mode byte, then clock byte), a DMA configuration byte, per-endpoint stall bits and a two-byte interrupt register. Endpoint status bytes come in from the rest of the controller. Reading them through the bus also retires the matching endpoint interrupt flag. An active-low interrupt pin is driven from the pending flags, from received start-of-frame pulses, or from both, as two configuration bits select.

Top module: `cpi_regif`

## Requirements
- R1: After reset: irq_n=1, dev_addr=0, func_en=0, ep_enable=0, mode_cfg=06h, clk_cfg=0Bh, dma_cfg=00h, ep_stall=0, bus_dout_oe=0.
- R2: After opcode D0h, the first data write loads dev_addr from bits 6:0 and func_en from bit 7.
- R3: A pulse on ev_bus_reset sets dev_addr to 0 and func_en to 1, and it sets interrupt byte 0 bit 6. It takes priority over a bus write in the same cycle.
- R4: After opcode F3h, the first data write loads mode_cfg and the second loads clk_cfg.
- R5: Opcode D8h stores bit 0 as the endpoint-enable bit. ep_enable is high only while that bit and func_en are both 1.
- R6: Opcode F4h returns two bytes in this order. Byte 0 holds endpoint flags 0..5 in bits 0..5, bus reset in bit 6 and suspend change in bit 7. Byte 1 holds DMA end in bit 0. Reading byte 0 clears bits 6 and 7, reading byte 1 clears DMA end, and the endpoint flags are left unchanged.
- R7: A read after opcode 40h+i (i = 0..5) returns ep_txn_status byte i and clears endpoint flag i only.
- R8: A write after opcode 40h+i sets ep_stall[i] to bit 0 of the data byte.
- R9: A read after opcode 80h+i returns ep_buf_status byte i and clears no flag.
- R10: Pin source. If clk_cfg bit 7 is 1, only ev_sof pulls irq_n low. Otherwise, with dma_cfg bit 5 at 0, any pending flag pulls it low; with that bit at 1, any pending flag or ev_sof pulls it low. An ev_sof pulse gives a one-cycle low.
- R11: Data accesses beyond the opcode's budget change nothing and read as 00h. Budgets: D0h write 1, D8h write 1, F3h write 2, FBh 1, F4h read 2, 40h+i 1, 80h+i read 1. A new command restarts the count.
- R12: bus_dout_oe is high only while chip select and the read strobe are both low. At other times bus_dout is 00h.
- R13: After opcode FBh, a write loads dma_cfg, and a read in a later FBh command returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low; data taken at its rising edge |
| bus_cmd | input | 1 | 1 = command phase, 0 = data phase |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data |
| bus_dout_oe | output | 1 | Read data valid / drive enable |
| ev_sof | input | 1 | Start-of-frame received pulse |
| ev_bus_reset | input | 1 | USB bus reset pulse |
| ev_suspend_chg | input | 1 | Suspend state change pulse |
| ev_dma_end | input | 1 | End of DMA transfer pulse |
| ev_ep_done | input | NUM_EP | Per-endpoint transaction pulse |
| ep_txn_status | input | 8*NUM_EP | Last-transaction status byte per endpoint |
| ep_buf_status | input | 8*NUM_EP | Buffer status byte per endpoint |
| irq_n | output | 1 | Interrupt pin, active low |
| dev_addr | output | 7 | Device address |
| func_en | output | 1 | Function enable |
| ep_enable | output | 1 | Effective enable of the non-control endpoints |
| mode_cfg | output | 8 | Mode byte |
| clk_cfg | output | 8 | Clock-division byte |
| dma_cfg | output | 8 | DMA configuration byte |
| ep_stall | output | NUM_EP | Stall bit per endpoint |

## Verification
The bench builds the block with NUM_EP = 6, so it can sweep every endpoint opcode from 40h to 45h and from 80h to 85h. For each endpoint it computes the returned status byte and the surviving interrupt flags arithmetically. It also walks through all three pin-source selections, each with and without pending flags and SOF pulses. It further covers budget overruns on one-byte and two-byte commands, including the case where a new opcode restarts the count.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;

  localparam logic [BYTE_W-1:0] OP_ADDR = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_EPEN = 8'hD8;
  localparam logic [BYTE_W-1:0] OP_MODE = 8'hF3;
  localparam logic [BYTE_W-1:0] OP_DMA  = 8'hFB;
  localparam logic [BYTE_W-1:0] OP_IRQ  = 8'hF4;
  localparam logic [4:0]        OP_TXN_HI = 5'b01000;
  localparam logic [4:0]        OP_BUF_HI = 5'b10000;

  localparam logic [BYTE_W-1:0] MODE_RST = 8'h06;
  localparam logic [BYTE_W-1:0] CLK_RST  = 8'h0B;

  typedef enum logic [2:0] {
    K_NONE, K_ADDR, K_EPEN, K_MODE, K_DMA, K_IRQ, K_TXN, K_BUF
  } cmd_kind_e;
endpackage

// File: rtl/cpi_bus_front.sv
module cpi_bus_front
  import cpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cmd,
  input  logic [BYTE_W-1:0] din,
  output logic              cmd_stb,
  output logic              dwr_stb,
  output logic              drd_stb,
  output logic              rd_active,
  output logic [BYTE_W-1:0] wbyte
);
  logic              cs_q, rd_q, wr_q, cmd_q;
  logic [BYTE_W-1:0] din_q;
  logic              wr_act_p, rd_act_p, cmd_p;
  logic [BYTE_W-1:0] din_p;
  logic              wr_act, wr_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      cmd_q    <= 1'b0;
      din_q    <= '0;
      wr_act_p <= 1'b0;
      rd_act_p <= 1'b0;
      cmd_p    <= 1'b0;
      din_p    <= '0;
    end else begin
      cs_q     <= cs_n;
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      cmd_q    <= cmd;
      din_q    <= din;
      wr_act_p <= wr_act;
      rd_act_p <= rd_active;
      cmd_p    <= cmd_q;
      din_p    <= din_q;
    end
  end

  assign wr_act    = !cs_q && !wr_q;
  assign rd_active = !cs_q && !rd_q;
  assign wr_end    = wr_act_p && !wr_act;
  assign cmd_stb   = wr_end && cmd_p;
  assign dwr_stb   = wr_end && !cmd_p;
  assign drd_stb   = rd_act_p && !rd_active;
  assign wbyte     = din_p;
endmodule

// File: rtl/cpi_cmd_seq.sv
module cpi_cmd_seq
  import cpi_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int EPW    = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              dwr_stb,
  input  logic              drd_stb,
  input  logic [BYTE_W-1:0] byte_in,
  output cmd_kind_e         kind,
  output logic [EPW-1:0]    ep,
  output logic [IDX_W-1:0]  idx,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              rd_ok
);
  function automatic cmd_kind_e decode(input logic [BYTE_W-1:0] b);
    cmd_kind_e k;
    k = K_NONE;
    if (b == OP_ADDR) k = K_ADDR;
    else if (b == OP_EPEN) k = K_EPEN;
    else if (b == OP_MODE) k = K_MODE;
    else if (b == OP_DMA)  k = K_DMA;
    else if (b == OP_IRQ)  k = K_IRQ;
    else if (b[7:3] == OP_TXN_HI && int'(b[2:0]) < NUM_EP) k = K_TXN;
    else if (b[7:3] == OP_BUF_HI && int'(b[2:0]) < NUM_EP) k = K_BUF;
    return k;
  endfunction

  function automatic logic [IDX_W-1:0] wr_budget(input cmd_kind_e k);
    case (k)
      K_ADDR, K_EPEN, K_DMA, K_TXN: return IDX_W'(1);
      K_MODE:                       return IDX_W'(2);
      default:                      return '0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] rd_budget(input cmd_kind_e k);
    case (k)
      K_DMA, K_TXN, K_BUF: return IDX_W'(1);
      K_IRQ:               return IDX_W'(2);
      default:             return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      kind <= K_NONE;
      ep   <= '0;
      idx  <= '0;
    end else if (cmd_stb) begin
      kind <= decode(byte_in);
      ep   <= byte_in[EPW-1:0];
      idx  <= '0;
    end else if (acc_wr || acc_rd) begin
      idx  <= idx + 1'b1;
    end
  end

  assign rd_ok  = idx < rd_budget(kind);
  assign acc_wr = dwr_stb && (idx < wr_budget(kind));
  assign acc_rd = drd_stb && rd_ok;

  // R11
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst) idx <= IDX_W'(2));
  // R11
  cmd_restart_chk: assert property (@(posedge clk) disable iff (rst) cmd_stb |=> idx == '0);
endmodule

// File: rtl/cpi_cfg_regs.sv
module cpi_cfg_regs
  import cpi_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int EPW    = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  cmd_kind_e         kind,
  input  logic [EPW-1:0]    ep,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              bus_reset,
  output logic [6:0]        dev_addr,
  output logic              func_en,
  output logic              ep_en_bit,
  output logic [BYTE_W-1:0] mode_cfg,
  output logic [BYTE_W-1:0] clk_cfg,
  output logic [BYTE_W-1:0] dma_cfg,
  output logic [NUM_EP-1:0] ep_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr  <= '0;
      func_en   <= 1'b0;
      ep_en_bit <= 1'b0;
      mode_cfg  <= MODE_RST;
      clk_cfg   <= CLK_RST;
      dma_cfg   <= '0;
      ep_stall  <= '0;
    end else begin
      if (acc_wr) begin
        case (kind)
          K_ADDR: {func_en, dev_addr} <= wbyte;
          K_EPEN: ep_en_bit <= wbyte[0];
          K_MODE: begin
            if (idx == '0) mode_cfg <= wbyte;
            else           clk_cfg  <= wbyte;
          end
          K_DMA:  dma_cfg <= wbyte;
          K_TXN:  ep_stall[ep] <= wbyte[0];
          default: ;
        endcase
      end
      if (bus_reset) begin
        dev_addr <= '0;
        func_en  <= 1'b1;
      end
    end
  end

  // R3
  bus_reset_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (func_en && dev_addr == '0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(ep_stall));
endmodule

// File: rtl/cpi_irq_ctl.sv
module cpi_irq_ctl #(
  parameter int NUM_EP = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] ev_ep,
  input  logic              ev_bus_reset,
  input  logic              ev_susp,
  input  logic              ev_eot,
  input  logic              ev_sof,
  input  logic [NUM_EP-1:0] clr_ep,
  input  logic              clr_top,
  input  logic              clr_eot,
  input  logic              sof_only,
  input  logic              pin_mode,
  output logic [NUM_EP-1:0] ep_flag,
  output logic              brst_flag,
  output logic              susp_flag,
  output logic              eot_flag,
  output logic              irq_n
);
  logic pending, want;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk) begin
      if (rst)            ep_flag[i] <= 1'b0;
      else if (ev_ep[i])  ep_flag[i] <= 1'b1;
      else if (clr_ep[i]) ep_flag[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brst_flag <= 1'b0;
      susp_flag <= 1'b0;
      eot_flag  <= 1'b0;
      irq_n     <= 1'b1;
    end else begin
      if (ev_bus_reset) brst_flag <= 1'b1;
      else if (clr_top) brst_flag <= 1'b0;
      if (ev_susp)      susp_flag <= 1'b1;
      else if (clr_top) susp_flag <= 1'b0;
      if (ev_eot)       eot_flag  <= 1'b1;
      else if (clr_eot) eot_flag  <= 1'b0;
      irq_n <= !want;
    end
  end

  assign pending = (|ep_flag) || brst_flag || susp_flag || eot_flag;

  always_comb begin
    if (sof_only)      want = ev_sof;
    else if (pin_mode) want = pending || ev_sof;
    else               want = pending;
  end

  // R6
  top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_top && !ev_bus_reset) |=> !brst_flag);
  // R10
  sof_only_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && $past(sof_only)) |-> $past(ev_sof));
  // R7
  ep_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ep == '0) |=> ((ep_flag & ~$past(ep_flag)) == (ep_flag & $past(ev_ep)) ||
                        (ep_flag & ~$past(ep_flag)) == '0));
endmodule

// File: rtl/cpi_regif.sv
module cpi_regif
  import cpi_pkg::*;
#(
  parameter int NUM_EP = 6
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_cs_n,
  input  logic                     bus_rd_n,
  input  logic                     bus_wr_n,
  input  logic                     bus_cmd,
  input  logic [7:0]               bus_din,
  output logic [7:0]               bus_dout,
  output logic                     bus_dout_oe,
  input  logic                     ev_sof,
  input  logic                     ev_bus_reset,
  input  logic                     ev_suspend_chg,
  input  logic                     ev_dma_end,
  input  logic [NUM_EP-1:0]        ev_ep_done,
  input  logic [NUM_EP*8-1:0]      ep_txn_status,
  input  logic [NUM_EP*8-1:0]      ep_buf_status,
  output logic                     irq_n,
  output logic [6:0]               dev_addr,
  output logic                     func_en,
  output logic                     ep_enable,
  output logic [7:0]               mode_cfg,
  output logic [7:0]               clk_cfg,
  output logic [7:0]               dma_cfg,
  output logic [NUM_EP-1:0]        ep_stall
);
  localparam int EPW = 3;

  logic              cmd_stb, dwr_stb, drd_stb, rd_active;
  logic [BYTE_W-1:0] wbyte;
  cmd_kind_e         kind;
  logic [EPW-1:0]    ep;
  logic [IDX_W-1:0]  idx;
  logic              acc_wr, acc_rd, rd_ok;
  logic              ep_en_bit;
  logic [NUM_EP-1:0] ep_flag, clr_ep;
  logic              brst_flag, susp_flag, eot_flag;
  logic              clr_top, clr_eot;
  logic [BYTE_W-1:0] irq_lo, rd_mux;

  cpi_bus_front u_front (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .cmd(bus_cmd), .din(bus_din), .cmd_stb(cmd_stb), .dwr_stb(dwr_stb),
    .drd_stb(drd_stb), .rd_active(rd_active), .wbyte(wbyte)
  );

  cpi_cmd_seq #(.NUM_EP(NUM_EP), .EPW(EPW)) u_seq (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .dwr_stb(dwr_stb), .drd_stb(drd_stb),
    .byte_in(wbyte), .kind(kind), .ep(ep), .idx(idx), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .rd_ok(rd_ok)
  );

  cpi_cfg_regs #(.NUM_EP(NUM_EP), .EPW(EPW)) u_regs (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .kind(kind), .ep(ep), .idx(idx),
    .wbyte(wbyte), .bus_reset(ev_bus_reset), .dev_addr(dev_addr),
    .func_en(func_en), .ep_en_bit(ep_en_bit), .mode_cfg(mode_cfg),
    .clk_cfg(clk_cfg), .dma_cfg(dma_cfg), .ep_stall(ep_stall)
  );

  always_comb begin
    clr_ep = '0;
    if (acc_rd && kind == K_TXN) clr_ep[ep] = 1'b1;
  end
  assign clr_top = acc_rd && kind == K_IRQ && idx == '0;
  assign clr_eot = acc_rd && kind == K_IRQ && idx == IDX_W'(1);

  cpi_irq_ctl #(.NUM_EP(NUM_EP)) u_irq (
    .clk(clk), .rst(rst), .ev_ep(ev_ep_done), .ev_bus_reset(ev_bus_reset),
    .ev_susp(ev_suspend_chg), .ev_eot(ev_dma_end), .ev_sof(ev_sof),
    .clr_ep(clr_ep), .clr_top(clr_top), .clr_eot(clr_eot),
    .sof_only(clk_cfg[7]), .pin_mode(dma_cfg[5]), .ep_flag(ep_flag),
    .brst_flag(brst_flag), .susp_flag(susp_flag), .eot_flag(eot_flag),
    .irq_n(irq_n)
  );

  assign ep_enable = func_en && ep_en_bit;

  always_comb begin
    irq_lo = '0;
    for (int i = 0; i < NUM_EP; i++) irq_lo[i] = ep_flag[i];
    irq_lo[6] = brst_flag;
    irq_lo[7] = susp_flag;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      case (kind)
        K_DMA: rd_mux = dma_cfg;
        K_IRQ: rd_mux = (idx == '0) ? irq_lo : {7'b0, eot_flag};
        K_TXN: rd_mux = ep_txn_status[int'(ep)*8 +: 8];
        K_BUF: rd_mux = ep_buf_status[int'(ep)*8 +: 8];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout    <= '0;
      bus_dout_oe <= 1'b0;
    end else begin
      bus_dout    <= rd_active ? rd_mux : '0;
      bus_dout_oe <= rd_active;
    end
  end

  // R12
  dout_oe_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bus_dout_oe |-> $past(!bus_cs_n && !bus_rd_n, 2));
  // R5
  ep_enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ep_enable && !$past(ev_bus_reset)) |-> $past(func_en) || $past(acc_wr));
endmodule

// File: tb/cpi_regif_test.sv
module cpi_regif_test;
  localparam int NUM_EP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_cmd = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic bus_dout_oe;
  logic ev_sof = 0, ev_bus_reset = 0, ev_suspend_chg = 0, ev_dma_end = 0;
  logic [NUM_EP-1:0] ev_ep_done = '0;
  logic [NUM_EP*8-1:0] ep_txn_status, ep_buf_status;
  logic irq_n, func_en, ep_enable;
  logic [6:0] dev_addr;
  logic [7:0] mode_cfg, clk_cfg, dma_cfg;
  logic [NUM_EP-1:0] ep_stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_lo = '0;
  logic       exp_eot = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] txn_val(input int i);
    return 8'(8'h05 + 8'h11 * i);
  endfunction
  function automatic logic [7:0] buf_val(input int i);
    return 8'(8'hC3 ^ (i << 2));
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      ep_txn_status[i*8 +: 8] = txn_val(i);
      ep_buf_status[i*8 +: 8] = buf_val(i);
    end
  end

  cpi_regif #(.NUM_EP(NUM_EP)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [7:0] v);
    @(negedge clk);
    bus_cs_n = 0; bus_cmd = c; bus_din = v; bus_wr_n = 0;
    repeat (3) @(negedge clk);
    bus_wr_n = 1;
    repeat (2) @(negedge clk);
    bus_cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(output logic [7:0] v, output logic oe);
    @(negedge clk);
    bus_cs_n = 0; bus_cmd = 0; bus_rd_n = 0;
    repeat (4) @(negedge clk);
    v = bus_dout; oe = bus_dout_oe;
    bus_rd_n = 1;
    repeat (2) @(negedge clk);
    bus_cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    logic [7:0] v; logic oe;
    bus_rd(v, oe);
    chk({tag, " data"}, v, exp);
    chk("R12 oe during read", oe, 1);
  endtask

  task automatic irq_chk(input string tag);
    logic [7:0] v; logic oe;
    bus_wr(1, 8'hF4);
    bus_rd(v, oe); chk({tag, " R6 byte0"}, v, exp_lo);
    exp_lo[7:6] = 2'b00;
    bus_rd(v, oe); chk({tag, " R6 byte1"}, v, {7'b0, exp_eot});
    exp_eot = 0;
  endtask

  task automatic pulse_ev(input logic [NUM_EP-1:0] eps, input logic br, input logic su,
                          input logic eo);
    @(negedge clk);
    ev_ep_done = eps; ev_bus_reset = br; ev_suspend_chg = su; ev_dma_end = eo;
    @(negedge clk);
    ev_ep_done = '0; ev_bus_reset = 0; ev_suspend_chg = 0; ev_dma_end = 0;
    @(negedge clk);
  endtask

  task automatic sof_chk(input string tag, input logic exp_low);
    @(negedge clk); ev_sof = 1;
    @(negedge clk); ev_sof = 0;
    chk({tag, " R10 sof pulse"}, irq_n, !exp_low);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; logic oe;
    logic [NUM_EP-1:0] exp_stall;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset values
    chk("R1 irq_n", irq_n, 1);
    chk("R1 dev_addr", dev_addr, 0);
    chk("R1 func_en", func_en, 0);
    chk("R1 ep_enable", ep_enable, 0);
    chk("R1 mode_cfg", mode_cfg, 8'h06);
    chk("R1 clk_cfg", clk_cfg, 8'h0B);
    chk("R1 dma_cfg", dma_cfg, 0);
    chk("R1 ep_stall", ep_stall, 0);
    chk("R1 oe", bus_dout_oe, 0);

    // R2 address/enable sweep
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      a = 8'(k * 37 + 3);
      bus_wr(1, 8'hD0); bus_wr(0, a);
      chk("R2 dev_addr", dev_addr, a[6:0]);
      chk("R2 func_en", func_en, a[7]);
    end

    // R5 endpoint enable gating
    bus_wr(1, 8'hD0); bus_wr(0, 8'h05);
    bus_wr(1, 8'hD8); bus_wr(0, 8'h01);
    chk("R5 disabled function", ep_enable, 0);
    bus_wr(1, 8'hD0); bus_wr(0, 8'h85);
    chk("R5 enabled function", ep_enable, 1);
    bus_wr(1, 8'hD8); bus_wr(0, 8'h00);
    chk("R5 bit cleared", ep_enable, 0);

    // R11 budget overrun on one-byte command, then restart
    bus_wr(1, 8'hD0); bus_wr(0, 8'h81); bus_wr(0, 8'h12);
    chk("R11 extra write ignored", {func_en, dev_addr}, 8'h81);
    bus_wr(1, 8'hD0); bus_wr(0, 8'h12);
    chk("R11 new command restarts", {func_en, dev_addr}, 8'h12);

    // R4 two-byte mode command with overrun (R11)
    bus_wr(1, 8'hF3); bus_wr(0, 8'hA5); bus_wr(0, 8'h3C); bus_wr(0, 8'h99);
    chk("R4 mode byte", mode_cfg, 8'hA5);
    chk("R4 clock byte", clk_cfg, 8'h3C);
    bus_wr(1, 8'hF3); bus_wr(0, 8'h06); bus_wr(0, 8'h0B);
    chk("R4 restore", clk_cfg, 8'h0B);

    // R13 DMA register
    bus_wr(1, 8'hFB); bus_wr(0, 8'h5A);
    chk("R13 dma write", dma_cfg, 8'h5A);
    bus_wr(1, 8'hFB); rd_chk("R13 dma read", 8'h5A);
    rd_chk("R11 read past budget", 8'h00);
    chk("R12 oe after read", bus_dout_oe, 0);
    chk("R12 dout after read", bus_dout, 0);
    bus_wr(1, 8'hFB); bus_wr(0, 8'h00);

    // R3 bus reset
    bus_wr(1, 8'hD0); bus_wr(0, 8'h33);
    pulse_ev('0, 1, 0, 0); exp_lo[6] = 1;
    chk("R3 addr cleared", dev_addr, 0);
    chk("R3 enable set", func_en, 1);
    chk("R10 pending any", irq_n, 0);
    irq_chk("R3");

    // R6 clear-on-read split
    pulse_ev(6'b000100, 0, 1, 1);
    exp_lo[7] = 1; exp_lo[2] = 1; exp_eot = 1;
    irq_chk("R6 first");
    irq_chk("R6 second");
    chk("R6 ep flag keeps pin low", irq_n, 0);
    bus_wr(1, 8'h42); rd_chk("R7 ep2", txn_val(2)); exp_lo[2] = 0;
    chk("R7 pin released", irq_n, 1);

    // R7 sweep: retire flags one endpoint at a time
    pulse_ev('1, 0, 0, 0); exp_lo[5:0] = 6'h3F;
    for (int i = 0; i < NUM_EP; i++) begin
      bus_wr(1, 8'(8'h40 + i)); rd_chk("R7 txn status", txn_val(i));
      exp_lo[i] = 0;
      irq_chk("R7 remaining");
    end
    chk("R7 all retired", irq_n, 1);

    // R9 buffer status does not clear
    for (int i = 0; i < NUM_EP; i++) begin
      pulse_ev(6'(1 << i), 0, 0, 0); exp_lo[i] = 1;
      bus_wr(1, 8'(8'h80 + i)); rd_chk("R9 buf status", buf_val(i));
      irq_chk("R9 flag kept");
      bus_wr(1, 8'(8'h40 + i)); rd_chk("R7 txn status", txn_val(i));
      exp_lo[i] = 0;
    end

    // R8 stall writes
    exp_stall = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      bus_wr(1, 8'(8'h40 + i)); bus_wr(0, 8'hFF);
      exp_stall[i] = 1;
      chk("R8 stall set", ep_stall, exp_stall);
    end
    for (int i = 0; i < NUM_EP; i += 2) begin
      bus_wr(1, 8'(8'h40 + i)); bus_wr(0, 8'hFE);
      exp_stall[i] = 0;
      chk("R8 stall clear", ep_stall, exp_stall);
    end

    // R10 pin source modes
    sof_chk("mode any, idle", 0);
    pulse_ev(6'b000001, 0, 0, 0); exp_lo[0] = 1;
    chk("R10 any flag", irq_n, 0);
    bus_wr(1, 8'hFB); bus_wr(0, 8'h20);
    chk("R10 any|sof flag", irq_n, 0);
    bus_wr(1, 8'h40); rd_chk("R7 txn status", txn_val(0)); exp_lo[0] = 0;
    chk("R10 any|sof idle", irq_n, 1);
    sof_chk("mode any|sof", 1);
    chk("R10 pulse one cycle", irq_n, 1);
    bus_wr(1, 8'hF3); bus_wr(0, 8'h06); bus_wr(0, 8'h8B);
    pulse_ev(6'b000010, 0, 0, 0); exp_lo[1] = 1;
    chk("R10 sof-only ignores flag", irq_n, 1);
    sof_chk("mode sof-only", 1);
    bus_wr(1, 8'hFB); bus_wr(0, 8'h00);
    sof_chk("mode sof-only pin bit 0", 1);
    bus_wr(1, 8'hF3); bus_wr(0, 8'h06); bus_wr(0, 8'h0B);
    chk("R10 back to any", irq_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule